// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

A 32-pin general-purpose I/O block behind a plain word-wide register port. Each pin can be an input or an output. Outputs are driven from a data register, and a status view returns the synchronised pad levels. Every pin also has its own event detector. Each detector watches for a low level, a high level, a rising edge or a falling edge, and a per-pin override makes a detector respond to both edges.

Detected events are held in a sticky status register until software writes ones to clear them. A mask register picks which held events reach the two interrupt request lines. The lower line serves pins 0 to 15 and the upper line serves pins 16 to 31.

Register reads are combinational from the address. A write takes effect at the clock edge on which the bus select and the write enable are both high. Register offsets are byte offsets and are decoded from bits [4:2] of the address.

Top module: `gpio_irq_block`

## Requirements
- R1: While reset is low, every register reads zero, `irq` is 0, and `pad_oe` and `pad_out` are all zero.
- R2: A write to the direction register (offset 0x04) appears on `pad_oe`, and a write to the data register (offset 0x00) appears on `pad_out`. Both read back at their offsets. A direction bit of 1 makes the pin an output.
- R3: The pad status register (offset 0x08) returns `pad_in` after two clock edges of synchronisation.
- R4: A pin's 2-bit trigger code selects 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. Pin n < 16 takes its code from offset 0x0C bits [2n+1:2n]. Pin n >= 16 takes it from offset 0x10 bits [2(n-16)+1:2(n-16)].
- R5: With code 2, a pad rising sets that pin's status bit (offset 0x18) on the third clock edge after the change, and not earlier.
- R6: With code 3, only a falling pad sets the status bit. A rising pad on that pin sets nothing.
- R7: With a level code, the status bit is set on every cycle that the level holds. When a clearing write and a set fall in the same cycle, the bit stays 1.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. No bit of the status register drops to 0 without a clearing write.
- R9: When a pin's bit in the edge-select register (offset 0x1C) is 1, both edges set its status bit and its trigger code is ignored.
- R10: `irq[0]` is high when any pin 0–15 has both its status and mask (offset 0x14) bits set. `irq[1]` does the same for pins 16–31. With the mask all zero, `irq` is 0.
- R11: The configuration, mask and edge-select registers read back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Register access select |
| bus_we | input | 1 | Write enable, qualified by `bus_cs` |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output levels for the pads |
| pad_oe | output | 32 | Output enable per pad |
| irq | output | 2 | Interrupt requests, bit 0 for pins 0–15 and bit 1 for pins 16–31 |

## Verification
The bench builds the block with its default `SYNC_STAGES` of 2. Its edge-count checks therefore expect the pad status two edges after a pad change and a status bit three edges after it, and they also check that the bit is still clear one edge earlier. The tests place events on pins on both sides of the 15/16 boundary. This exercises both configuration words and both interrupt lines, and it includes a falling trigger and a low-level trigger in the upper word. The override and the set-beats-clear race are both reached by holding pads steady across clearing writes.

// File: rtl/gpio_irq_block.sv
module gpio_irq_block #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pad_in,
  output logic [31:0] pad_out,
  output logic [31:0] pad_oe,
  output logic [1:0]  irq
);
  localparam int PINS = 32;
  localparam int HALF = PINS / 2;
  localparam logic [2:0] A_DATA = 3'd0, A_DIR = 3'd1, A_PAD = 3'd2, A_CFGLO = 3'd3,
                         A_CFGHI = 3'd4, A_MASK = 3'd5, A_STAT = 3'd6, A_BOTH = 3'd7;

  logic [PINS-1:0] data_q, dir_q, mask_q, st_q, both_q, prev_q, cur, hit;
  logic [31:0] cfg_lo_q, cfg_hi_q;
  logic [SYNC_STAGES-1:0][PINS-1:0] sync_q;

  wire       wr_en = bus_cs && bus_we;
  wire [2:0] widx  = bus_addr[4:2];
  wire [PINS-1:0] clr = (wr_en && widx == A_STAT) ? bus_wdata : '0;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= cur;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [1:0] code;
    if (i < HALF) begin : g_lo
      assign code = cfg_lo_q[2*i +: 2];
    end else begin : g_hi
      assign code = cfg_hi_q[2*(i-HALF) +: 2];
    end
    always_comb begin
      if (both_q[i]) hit[i] = cur[i] ^ prev_q[i];
      else begin
        case (code)
          2'd0:    hit[i] = ~cur[i];
          2'd1:    hit[i] = cur[i];
          2'd2:    hit[i] = cur[i] & ~prev_q[i];
          default: hit[i] = ~cur[i] & prev_q[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      both_q   <= '0;
      st_q     <= '0;
    end else begin
      if (wr_en) begin
        case (widx)
          A_DATA:  data_q   <= bus_wdata;
          A_DIR:   dir_q    <= bus_wdata;
          A_CFGLO: cfg_lo_q <= bus_wdata;
          A_CFGHI: cfg_hi_q <= bus_wdata;
          A_MASK:  mask_q   <= bus_wdata;
          A_BOTH:  both_q   <= bus_wdata;
          default: ;
        endcase
      end
      st_q <= (st_q & ~clr) | hit;
    end
  end

  always_comb begin
    case (bus_addr[4:2])
      A_DATA:  bus_rdata = data_q;
      A_DIR:   bus_rdata = dir_q;
      A_PAD:   bus_rdata = cur;
      A_CFGLO: bus_rdata = cfg_lo_q;
      A_CFGHI: bus_rdata = cfg_hi_q;
      A_MASK:  bus_rdata = mask_q;
      A_STAT:  bus_rdata = st_q;
      default: bus_rdata = both_q;
    endcase
  end

  wire [PINS-1:0] pend = st_q & mask_q;
  assign irq     = {|pend[PINS-1:HALF], |pend[HALF-1:0]};
  assign pad_out = data_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_block_chk.sv
module gpio_irq_block_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_cs,
  input logic        bus_we,
  input logic [4:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] pad_out,
  input logic [31:0] pad_oe,
  input logic [1:0]  irq,
  input logic [31:0] status,
  input logic [31:0] mask
);
  wire wr = bus_cs && bus_we;

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (irq == 2'b00 && pad_oe == '0 && pad_out == '0);
    end
  end

  a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr[4:2] == 3'd1) |=> pad_oe == $past(bus_wdata));

  a_r2_data_to_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr[4:2] == 3'd0) |=> pad_out == $past(bus_wdata));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr[4:2] == 3'd6) |=> ((status & $past(status)) == $past(status)));

  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> irq == 2'b00);
endmodule

bind gpio_irq_block gpio_irq_block_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
  .status(st_q), .mask(mask_q)
);

// File: tb/gpio_irq_block_bench.sv
`timescale 1ns/1ps
module gpio_irq_block_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cs = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, pad_in = '0;
  logic [31:0] bus_rdata, pad_out, pad_oe;
  logic [1:0] irq;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  gpio_irq_block u_gpio_irq_block (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  localparam logic [4:0] O_DATA = 5'h00, O_DIR = 5'h04, O_PAD = 5'h08, O_CLO = 5'h0C,
                         O_CHI = 5'h10, O_MASK = 5'h14, O_STAT = 5'h18, O_BOTH = 5'h1C;
  localparam logic [31:0] RISE_ALL = 32'hAAAA_AAAA;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk_reg(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) chk_reg("R1 reg", 5'(a * 4), 32'h0);
    check("R1 irq", {30'd0, irq}, 32'h0);
    check("R1 oe", pad_oe, 32'h0);
    check("R1 out", pad_out, 32'h0);
  endtask

  task automatic t_regs;
    wr(O_MASK, 32'hDEAD_BEEF);
    wr(O_BOTH, 32'h0F0F_0F0F);
    wr(O_CLO, 32'h1234_5678);
    wr(O_CHI, 32'h9ABC_DEF0);
    chk_reg("R11 mask", O_MASK, 32'hDEAD_BEEF);
    chk_reg("R11 both", O_BOTH, 32'h0F0F_0F0F);
    chk_reg("R11 cfglo", O_CLO, 32'h1234_5678);
    chk_reg("R11 cfghi", O_CHI, 32'h9ABC_DEF0);
    wr(O_MASK, 0);
    wr(O_BOTH, 0);
    wr(O_CLO, RISE_ALL);
    wr(O_CHI, RISE_ALL);
  endtask

  task automatic t_dir_data;
    wr(O_DIR, 32'hF0F0_1234);
    wr(O_DATA, 32'hA5A5_5A5A);
    check("R2 oe", pad_oe, 32'hF0F0_1234);
    check("R2 out", pad_out, 32'hA5A5_5A5A);
    chk_reg("R2 dir rb", O_DIR, 32'hF0F0_1234);
    chk_reg("R2 data rb", O_DATA, 32'hA5A5_5A5A);
  endtask

  task automatic t_pad_status;
    pad_in = 32'h1234_5678;
    ticks(1);
    chk_reg("R3 early", O_PAD, 32'h0);
    ticks(1);
    chk_reg("R3 synced", O_PAD, 32'h1234_5678);
    pad_in = 0;
    ticks(4);
    wr(O_STAT, 32'hFFFF_FFFF);
    chk_reg("R8 cleared", O_STAT, 32'h0);
  endtask

  task automatic t_rising;
    pad_in = (32'd1 << 3) | (32'd1 << 20);
    ticks(2);
    chk_reg("R5 not yet", O_STAT, 32'h0);
    ticks(1);
    chk_reg("R5 R4 rising", O_STAT, 32'h0010_0008);
    wr(O_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_falling;
    wr(O_CHI, 32'hAAAA_ABAA);
    wr(O_STAT, 32'hFFFF_FFFF);
    pad_in = 0;
    ticks(3);
    chk_reg("R6 R4 falling", O_STAT, 32'd1 << 20);
    wr(O_STAT, 32'hFFFF_FFFF);
    pad_in = 32'd1 << 20;
    ticks(3);
    chk_reg("R6 rise ignored", O_STAT, 32'h0);
    pad_in = 0;
    wr(O_CHI, RISE_ALL);
    ticks(2);
    wr(O_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_level;
    wr(O_CLO, 32'hAAAA_A6AA);
    wr(O_CHI, 32'hAAAA_A3AA);
    pad_in = 32'd1 << 5;
    ticks(4);
    chk_reg("R7 R4 levels", O_STAT, 32'h0020_0020);
    wr(O_STAT, 32'hFFFF_FFFF);
    chk_reg("R7 set wins", O_STAT, 32'h0020_0020);
    wr(O_CLO, RISE_ALL);
    wr(O_CHI, RISE_ALL);
    pad_in = 0;
    ticks(4);
    wr(O_STAT, 32'hFFFF_FFFF);
    chk_reg("R7 released", O_STAT, 32'h0);
  endtask

  task automatic t_w1c;
    pad_in = 32'h0000_0F00;
    ticks(3);
    chk_reg("R8 setup", O_STAT, 32'h0000_0F00);
    wr(O_STAT, 32'h0);
    chk_reg("R8 zero write", O_STAT, 32'h0000_0F00);
    wr(O_STAT, 32'h0000_0200);
    chk_reg("R8 one bit", O_STAT, 32'h0000_0D00);
    wr(O_STAT, 32'hFFFF_FFFF);
    chk_reg("R8 all", O_STAT, 32'h0);
    pad_in = 0;
    ticks(4);
  endtask

  task automatic t_both;
    wr(O_BOTH, 32'd1 << 7);
    pad_in = (32'd1 << 7) | (32'd1 << 8);
    ticks(3);
    chk_reg("R9 rise", O_STAT, 32'h0000_0180);
    wr(O_STAT, 32'hFFFF_FFFF);
    pad_in = 0;
    ticks(3);
    chk_reg("R9 fall", O_STAT, 32'h0000_0080);
    wr(O_STAT, 32'hFFFF_FFFF);
    wr(O_BOTH, 0);
  endtask

  task automatic t_irq;
    pad_in = (32'd1 << 3) | (32'd1 << 20);
    ticks(3);
    check("R10 masked", {30'd0, irq}, 32'd0);
    wr(O_MASK, 32'd1 << 3);
    check("R10 low line", {30'd0, irq}, 32'd1);
    wr(O_MASK, 32'd1 << 20);
    check("R10 high line", {30'd0, irq}, 32'd2);
    wr(O_MASK, (32'd1 << 3) | (32'd1 << 20));
    check("R10 both", {30'd0, irq}, 32'd3);
    wr(O_STAT, 32'd1 << 3);
    check("R10 after clear", {30'd0, irq}, 32'd2);
    wr(O_MASK, 0);
    check("R10 unmasked off", {30'd0, irq}, 32'd0);
    wr(O_STAT, 32'hFFFF_FFFF);
    pad_in = 0;
    ticks(4);
  endtask

  initial begin
    #10;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_regs;
    t_dir_data;
    t_pad_status;
    t_rising;
    t_falling;
    t_level;
    t_w1c;
    t_both;
    t_irq;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule